// File: doc/BRIEF.md
# Folded Constant-Geometry FFT Core

This block computes a forward radix-2 discrete Fourier transform of a small, fixed number of complex points (4, 8 or 16). It builds one column of two-point butterflies and reuses it for every stage. This works because the constant-geometry factorisation gives each stage the same wiring: butterfly `j` always reads the pair at positions `j` and `j + N/2`. Its two results are written back to positions `2j` and `2j + 1`. A parameter `PAR` sets how many butterflies the column holds. Each stage therefore takes `N/(2·PAR)` clock cycles, and a full transform takes `log2(N)·N/(2·PAR)` cycles of compute.

Samples arrive on a valid/ready stream and are collected in a capture bank. The column reads from the capture bank on the first pass. On later passes it reads from a feedback bank that holds the previous stage's results, and the two banks swap roles on every stage. Results leave on a second valid/ready stream in bit-reversed frequency order. Every butterfly output is halved, so the result is the DFT divided by N.

A small sequencer with three states controls the block. ST_LOAD accepts samples. The transition T_FULL (the N-th input handshake) moves it to ST_RUN, which steps through the stages and chunks. The transition T_DONE (last chunk of the last stage) moves it to ST_DRAIN, which presents the results. The transition T_EMPTY (the N-th output handshake) returns it to ST_LOAD.

Top module: `cgfft_core`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: in_ready is high only in the loading phase. Exactly N input handshakes (in_valid and in_ready both 1 at a rising edge) complete a load, and in_ready is low from the next cycle until the results have drained.
- R3: out_valid first rises exactly log2(N)·N/(2·PAR) clock cycles after the edge that took the N-th input sample (6 cycles for N=8, PAR=2).
- R4: The k-th output handshake of a transform (k = 0 … N−1) carries frequency bin bitrev(k), where bitrev reverses the log2(N) index bits (for N=8 the order is 0,4,2,6,1,5,3,7).
- R5: Each output component equals the exact DFT component, X[m] = Σ x[n]·e^(−j2πmn/N), divided by N and rounded, within ±4 LSB (inputs with components up to about ±12000).
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_re and out_im stay unchanged.
- R7: out_valid stays high for exactly N output handshakes. It then falls and in_ready rises on the next cycle.
- R8: in_valid and input data presented while in_ready is 0 are ignored and have no effect on the results of the transform in progress or the next one.
- R9: Idle cycles with in_valid low inside a load do not count as samples. A load spread over gaps gives the same results as a back-to-back load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Core is collecting samples |
| in_re | input | W | Input real part, signed |
| in_im | input | W | Input imaginary part, signed |
| out_valid | output | 1 | Result sample present |
| out_ready | input | 1 | Downstream takes the result |
| out_re | output | W | Result real part, signed, scaled by 1/N |
| out_im | output | W | Result imaginary part, signed, scaled by 1/N |

## Verification
An impulse at index 0 gives a flat spectrum, so it shows whether the halving at each stage is right without depending on the twiddle factors. A constant input puts all its energy in bin 0, which is the first output, so it checks the scaling and that the other bins stay empty. A real cosine and a complex exponential put energy in known bins, so they separate a correct bit-reversed order from a wrong one. An impulse at a non-zero index and a pseudo-random frame exercise every twiddle and both signs of the rotation. Gaps in the input, junk presented while the core is busy, and output back-pressure are mixed into these frames to tell timing faults from arithmetic faults.

// File: rtl/cgfft_pkg.sv
package cgfft_pkg;

    // Twiddle coefficient width: signed Q1.15
    localparam int TW = 16;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_t;

    // cos(2*pi*k/16) in Q1.15, k = 0..7
    function automatic logic signed [TW-1:0] cos16(input int k);
        case (k)
            0: return 16'sd32767;
            1: return 16'sd30274;
            2: return 16'sd23170;
            3: return 16'sd12540;
            4: return 16'sd0;
            5: return -16'sd12540;
            6: return -16'sd23170;
            7: return -16'sd30274;
            default: return 16'sd0;
        endcase
    endfunction

    // sin(2*pi*k/16) in Q1.15, k = 0..7
    function automatic logic signed [TW-1:0] sin16(input int k);
        case (k)
            0: return 16'sd0;
            1: return 16'sd12540;
            2: return 16'sd23170;
            3: return 16'sd30274;
            4: return 16'sd32767;
            5: return 16'sd30274;
            6: return 16'sd23170;
            7: return 16'sd12540;
            default: return 16'sd0;
        endcase
    endfunction

endpackage

// File: rtl/cgfft_twiddle.sv
module cgfft_twiddle
    import cgfft_pkg::*;
#(
    parameter int N_PTS = 8,
    parameter int KW    = 2
) (
    input  logic [KW-1:0]        k_i,
    output logic signed [TW-1:0] cos_o,
    output logic signed [TW-1:0] sin_o,
    output logic                 unity_o
);

    // Exponent of W_N expressed as an exponent of W_16
    localparam int STRIDE = 16 / N_PTS;

    int k16;

    always_comb begin
        k16     = int'(k_i) * STRIDE;
        cos_o   = cos16(k16);
        sin_o   = sin16(k16);
        unity_o = (k_i == '0);
    end

endmodule

// File: rtl/cgfft_bfly.sv
module cgfft_bfly
    import cgfft_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0]  a_re,
    input  logic signed [W-1:0]  a_im,
    input  logic signed [W-1:0]  b_re,
    input  logic signed [W-1:0]  b_im,
    input  logic signed [TW-1:0] cos_i,
    input  logic signed [TW-1:0] sin_i,
    input  logic                 unity_i,
    output logic signed [W-1:0]  u_re,
    output logic signed [W-1:0]  u_im,
    output logic signed [W-1:0]  v_re,
    output logic signed [W-1:0]  v_im
);

    localparam int EW = W + 1;
    localparam int PW = W + TW + 2;
    localparam logic signed [PW-1:0] RND = {{(PW-TW){1'b0}}, 1'b1, {(TW-1){1'b0}}};

    logic signed [EW-1:0] s_re, s_im, d_re, d_im;
    logic signed [PW-1:0] p_re, p_im;

    always_comb begin
        s_re = EW'(a_re) + EW'(b_re);
        s_im = EW'(a_im) + EW'(b_im);
        d_re = EW'(a_re) - EW'(b_re);
        d_im = EW'(a_im) - EW'(b_im);
        // (d_re + j d_im) * (cos - j sin), rounded, then halved
        p_re = PW'(d_re) * PW'(cos_i) + PW'(d_im) * PW'(sin_i) + RND;
        p_im = PW'(d_im) * PW'(cos_i) - PW'(d_re) * PW'(sin_i) + RND;
        u_re = s_re[W:1];
        u_im = s_im[W:1];
        if (unity_i) begin
            v_re = d_re[W:1];
            v_im = d_im[W:1];
        end else begin
            v_re = p_re[TW+W-1:TW];
            v_im = p_im[TW+W-1:TW];
        end
    end

endmodule

// File: rtl/cgfft_seq.sv
module cgfft_seq
    import cgfft_pkg::*;
#(
    parameter int N_PTS = 8,
    parameter int PAR   = 2,
    localparam int LOG2N  = $clog2(N_PTS),
    localparam int CHUNKS = N_PTS / (2 * PAR),
    localparam int AW     = LOG2N,
    localparam int SW     = (LOG2N > 1) ? $clog2(LOG2N) : 1,
    localparam int CW     = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          ld_fire,
    output logic          run_en,
    output logic [AW-1:0] ld_idx,
    output logic [AW-1:0] rd_idx,
    output logic [SW-1:0] stage,
    output logic [CW-1:0] chunk
);

    localparam logic [AW-1:0] LAST_A = AW'(N_PTS - 1);
    localparam logic [SW-1:0] LAST_S = SW'(LOG2N - 1);
    localparam logic [CW-1:0] LAST_C = CW'(CHUNKS - 1);

    seq_state_t state_q, state_d;
    logic       out_fire, last_ld, last_run, last_rd;

    always_comb begin
        ld_fire  = in_valid && (state_q == ST_LOAD);
        run_en   = (state_q == ST_RUN);
        out_fire = out_ready && (state_q == ST_DRAIN);
        last_ld  = (ld_idx == LAST_A);
        last_run = (stage == LAST_S) && (chunk == LAST_C);
        last_rd  = (rd_idx == LAST_A);
    end

    // Next-state logic: T_FULL, T_DONE, T_EMPTY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  if (ld_fire && last_ld)   state_d = ST_RUN;
            ST_RUN:   if (last_run)             state_d = ST_DRAIN;
            ST_DRAIN: if (out_fire && last_rd)  state_d = ST_LOAD;
            default:                            state_d = ST_LOAD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Handshake outputs
    always_comb begin
        in_ready  = (state_q == ST_LOAD);
        out_valid = (state_q == ST_DRAIN);
    end

    // Load, stage/chunk and drain counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_idx <= '0;
            rd_idx <= '0;
            stage  <= '0;
            chunk  <= '0;
        end else begin
            if (ld_fire)  ld_idx <= ld_idx + AW'(1);
            if (out_fire) rd_idx <= rd_idx + AW'(1);
            if (run_en) begin
                if (chunk == LAST_C) begin
                    chunk <= '0;
                    stage <= (stage == LAST_S) ? '0 : stage + SW'(1);
                end else begin
                    chunk <= chunk + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/cgfft_core.sv
module cgfft_core
    import cgfft_pkg::*;
#(
    parameter int N_PTS = 8,
    parameter int PAR   = 2,
    parameter int W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    output logic                out_valid,
    input  logic                out_ready,
    output logic signed [W-1:0] out_re,
    output logic signed [W-1:0] out_im
);

    localparam int LOG2N    = $clog2(N_PTS);
    localparam int CHUNKS   = N_PTS / (2 * PAR);
    localparam int AW       = LOG2N;
    localparam int JW       = AW - 1;
    localparam int SW       = (LOG2N > 1) ? $clog2(LOG2N) : 1;
    localparam int CW       = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
    localparam int OUT_BANK = LOG2N % 2;

    logic          ld_fire, run_en;
    logic [AW-1:0] ld_idx, rd_idx;
    logic [SW-1:0] stage;
    logic [CW-1:0] chunk;

    cgfft_seq #(.N_PTS(N_PTS), .PAR(PAR)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .ld_fire   (ld_fire),
        .run_en    (run_en),
        .ld_idx    (ld_idx),
        .rd_idx    (rd_idx),
        .stage     (stage),
        .chunk     (chunk)
    );

    // Capture bank (b0) and feedback bank (b1); they alternate per stage
    logic signed [W-1:0] b0_re [N_PTS];
    logic signed [W-1:0] b0_im [N_PTS];
    logic signed [W-1:0] b1_re [N_PTS];
    logic signed [W-1:0] b1_im [N_PTS];

    logic [PAR*W-1:0] u_re_f, u_im_f, v_re_f, v_im_f;

    for (genvar g = 0; g < PAR; g++) begin : g_col
        logic [JW-1:0]        j, k;
        logic signed [W-1:0]  a_re, a_im, b_re, b_im;
        logic signed [TW-1:0] tw_c, tw_s;
        logic                 tw_one;

        always_comb begin
            j = JW'(int'(chunk) * PAR + g);
            k = JW'((int'(j) >> stage) << stage);
            // Source select: capture bank on even stages, feedback bank on odd
            if (stage[0]) begin
                a_re = b1_re[{1'b0, j}];
                a_im = b1_im[{1'b0, j}];
                b_re = b1_re[{1'b1, j}];
                b_im = b1_im[{1'b1, j}];
            end else begin
                a_re = b0_re[{1'b0, j}];
                a_im = b0_im[{1'b0, j}];
                b_re = b0_re[{1'b1, j}];
                b_im = b0_im[{1'b1, j}];
            end
        end

        cgfft_twiddle #(.N_PTS(N_PTS), .KW(JW)) u_tw (
            .k_i     (k),
            .cos_o   (tw_c),
            .sin_o   (tw_s),
            .unity_o (tw_one)
        );

        cgfft_bfly #(.W(W)) u_bf (
            .a_re    (a_re),
            .a_im    (a_im),
            .b_re    (b_re),
            .b_im    (b_im),
            .cos_i   (tw_c),
            .sin_i   (tw_s),
            .unity_i (tw_one),
            .u_re    (u_re_f[g*W +: W]),
            .u_im    (u_im_f[g*W +: W]),
            .v_re    (v_re_f[g*W +: W]),
            .v_im    (v_im_f[g*W +: W])
        );
    end

    function automatic logic [AW-1:0] dst_idx(input logic [CW-1:0] ch, input int g, input logic odd);
        logic [JW-1:0] jj;
        jj = JW'(int'(ch) * PAR + g);
        return {jj, odd};
    endfunction

    always_ff @(posedge clk) begin
        if (ld_fire) begin
            b0_re[ld_idx] <= in_re;
            b0_im[ld_idx] <= in_im;
        end
        if (run_en) begin
            for (int g = 0; g < PAR; g++) begin
                if (stage[0]) begin
                    b0_re[dst_idx(chunk, g, 1'b0)] <= u_re_f[g*W +: W];
                    b0_im[dst_idx(chunk, g, 1'b0)] <= u_im_f[g*W +: W];
                    b0_re[dst_idx(chunk, g, 1'b1)] <= v_re_f[g*W +: W];
                    b0_im[dst_idx(chunk, g, 1'b1)] <= v_im_f[g*W +: W];
                end else begin
                    b1_re[dst_idx(chunk, g, 1'b0)] <= u_re_f[g*W +: W];
                    b1_im[dst_idx(chunk, g, 1'b0)] <= u_im_f[g*W +: W];
                    b1_re[dst_idx(chunk, g, 1'b1)] <= v_re_f[g*W +: W];
                    b1_im[dst_idx(chunk, g, 1'b1)] <= v_im_f[g*W +: W];
                end
            end
        end
    end

    // Stored order after the last stage is already bit-reversed
    if (OUT_BANK == 1) begin : g_out1
        assign out_re = b1_re[rd_idx];
        assign out_im = b1_im[rd_idx];
    end else begin : g_out0
        assign out_re = b0_re[rd_idx];
        assign out_im = b0_im[rd_idx];
    end

endmodule

// File: rtl/cgfft_core_chk.sv
module cgfft_core_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic signed [W-1:0] out_re,
    input logic signed [W-1:0] out_im
);

    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_load_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid));

    assert_compute_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(!in_ready));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

    assert_drain_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> ($past(out_ready) && in_ready));

endmodule

bind cgfft_core cgfft_core_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/cgfft_core_tb.sv
module cgfft_core_tb;

    localparam int NP   = 8;
    localparam int PP   = 2;
    localparam int LG   = 3;
    localparam int RUNC = LG * (NP / (2 * PP));
    localparam int TOL  = 4;
    localparam real PI2 = 6.283185307179586;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic out_ready = 1'b0;
    logic signed [15:0] in_re = '0;
    logic signed [15:0] in_im = '0;
    logic in_ready, out_valid;
    logic signed [15:0] out_re, out_im;

    always #10 clk = ~clk;

    cgfft_core #(.N_PTS(NP), .PAR(PP), .W(16)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    int eq_re[$], eq_im[$];
    int xr[NP], xi[NP];
    int ph = 0, ld = 0, rc = 0, oc = 0, er = 0, ei = 0, lf = 4660;
    bit stall_on = 0, gap_on = 0, hv = 0, done = 0;
    logic signed [15:0] hre = '0, him = '0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int bitrev(input int v);
        int r = 0;
        for (int b = 0; b < LG; b++) if (v[b]) r = r | (1 << (LG - 1 - b));
        return r;
    endfunction

    // Ideal DFT / N, listed in bit-reversed bin order (R4, R5)
    task automatic push_expected();
        for (int p = 0; p < NP; p++) begin
            real ar, ai, th;
            int m;
            m = bitrev(p);
            ar = 0.0;
            ai = 0.0;
            for (int n = 0; n < NP; n++) begin
                th = PI2 * real'(m * n) / real'(NP);
                ar = ar + real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
                ai = ai + real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
            end
            eq_re.push_back($rtoi($floor(ar / real'(NP) + 0.5)));
            eq_im.push_back($rtoi($floor(ai / real'(NP) + 0.5)));
        end
    endtask

    // Junk while busy (R8), optional idle gaps (R9)
    task automatic drive_frame();
        int i = 0;
        int gc = 0;
        while (i < NP) begin
            @(negedge clk);
            gc++;
            if (gap_on && (gc % 4 == 2)) begin
                in_valid = 1'b0;
                in_re = 16'sd777;
            end else begin
                in_valid = 1'b1;
                if (in_ready) begin
                    in_re = 16'(xr[i]);
                    in_im = 16'(xi[i]);
                    i++;
                end else begin
                    in_re = 16'(20000 - gc * 37);
                    in_im = 16'(-15000 + gc * 53);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_re = 16'sd31000;
        in_im = -16'sd31000;
    endtask

    // kind: 0 impulse at m, 1 constant, 2 real cosine bin m, 3 complex exponential bin m, 4 pseudo-random
    task automatic run_frame(input int kind, input int amp, input int m);
        for (int n = 0; n < NP; n++) begin
            real th;
            th = PI2 * real'(m * n) / real'(NP);
            case (kind)
                0: begin xr[n] = (n == m) ? amp : 0; xi[n] = 0; end
                1: begin xr[n] = amp; xi[n] = -amp / 2; end
                2: begin xr[n] = $rtoi(real'(amp) * $cos(th)); xi[n] = 0; end
                3: begin xr[n] = $rtoi(real'(amp) * $cos(th)); xi[n] = $rtoi(real'(amp) * $sin(th)); end
                default: begin
                    lf = lf * 1103515245 + 12345;
                    xr[n] = ((lf >> 8) & 16'h3FFF) - 8192;
                    lf = lf * 1103515245 + 12345;
                    xi[n] = ((lf >> 8) & 16'h3FFF) - 8192;
                end
            endcase
        end
        push_expected();
        drive_frame();
    endtask

    always @(negedge clk) out_ready <= stall_on ? ((cyc % 3) != 1) : 1'b1;

    // Per-cycle protocol model and output comparison
    always @(negedge clk) begin
        #1;
        cyc++;
        if (!rst_n) begin
            ph = 0; ld = 0; rc = 0; oc = 0; hv = 0;
        end else begin
            check(in_ready == (ph == 0), "R2 in_ready per cycle", int'(in_ready), int'(ph == 0));
            check(out_valid == (ph == 2), "R3/R7 out_valid per cycle", int'(out_valid), int'(ph == 2));
            if (hv) begin
                check(out_re == hre, "R6 held out_re", int'(out_re), int'(hre));
                check(out_im == him, "R6 held out_im", int'(out_im), int'(him));
            end
            if (out_valid && out_ready) begin
                if (eq_re.size() == 0) begin
                    check(1'b0, "R7 surplus output", int'(out_re), 0);
                end else begin
                    er = eq_re.pop_front();
                    ei = eq_im.pop_front();
                    check(iabs(int'(out_re) - er) <= TOL, "R4/R5/R8/R9 real bin", int'(out_re), er);
                    check(iabs(int'(out_im) - ei) <= TOL, "R4/R5/R8/R9 imag bin", int'(out_im), ei);
                end
            end
            hv  = out_valid && !out_ready;
            hre = out_re;
            him = out_im;
            case (ph)
                0: if (in_valid) begin
                       ld++;
                       if (ld == NP) begin ld = 0; rc = 0; ph = 1; end
                   end
                1: begin
                       rc++;
                       if (rc == RUNC) ph = 2;
                   end
                default: if (out_ready) begin
                       oc++;
                       if (oc == NP) begin oc = 0; ph = 0; end
                   end
            endcase
        end
        if (cyc > 20000 && !done) begin
            done = 1;
            check(1'b0, "watchdog expired", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        run_frame(0, 8000, 0);      // flat spectrum
        run_frame(1, 4000, 0);      // energy only in bin 0
        run_frame(2, 12000, 1);     // bins 1 and 7
        stall_on = 1;
        gap_on = 1;
        run_frame(3, 10000, 3);     // bin 3 only, gaps and back-pressure
        run_frame(0, 9000, 5);      // all twiddles, linear phase
        gap_on = 0;
        run_frame(4, 0, 0);         // pseudo-random
        stall_on = 0;
        run_frame(4, 0, 0);
        run_frame(2, 11000, 2);

        while (eq_re.size() != 0 || ph != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule